// File: doc/BRIEF.md
# Programmable-Threshold Synchronous FIFO

This block is a single-clock FIFO, 36 bits wide by default, with a parameterised power-of-two depth. It raises an almost-empty warning and an almost-full warning. Each warning compares the stored word count, or the free space, with its own threshold register. Both thresholds start from one of three built-in values, picked by a two-bit select that is sampled during master reset. Software can then replace them with a single parallel load strobe, or with a serial bit stream that a small loader state machine accepts.

Master reset also samples the timing mode. In standard mode, a read request moves the head word onto `dout` at the clock edge that accepts it. The flags are "not empty" on `out_flag` and "not full" on `in_flag`. In fall-through mode, the head word is moved into an output register without any request. `out_flag` then means "output word valid" and `in_flag` means "space for input". Partial reset empties the queue but leaves the thresholds and the mode as they are.

The serial loader has three states. It begins in `LD_EMPTY_OFS` after master reset. It moves from `LD_EMPTY_OFS` to `LD_FULL_OFS` when the last empty-threshold bit is shifted in. It moves from `LD_FULL_OFS` to `LD_LOCKED` when the last full-threshold bit is shifted in. It stays in `LD_LOCKED` until the next master reset. Partial reset does not change the loader state.

Top module: `prog_flag_fifo`

## Requirements
- R1: While `mrst_n` is low at a clock edge, the FIFO is emptied, `out_flag` goes to 0, `in_flag` to 1 and `almost_empty` to 1. Both thresholds are set from `fsel`: 2'b00 gives 8, 2'b01 gives 16, and 2'b10 or 2'b11 gives 64. The timing mode is taken from `fwft_sel` (1 = fall-through).
- R2: While `prst_n` is low at a clock edge, the FIFO is emptied, but the thresholds and the timing mode keep their values. Threshold loads are ignored while either reset is low.
- R3: In standard mode, `out_flag` is 1 when the count is non-zero and `in_flag` is 1 when the count is below DEPTH. A read accepted at an edge (`rd_en` high with `out_flag` high) puts the head word on `dout` at that same edge.
- R4: In fall-through mode, a word written into an empty FIFO appears on `dout` with `out_flag` high two edges after its write, with no read request. `rd_en` with `out_flag` high consumes that word.
- R5: A write and a read accepted at the same edge leave the level unchanged and keep the words in order.
- R6: A write while `in_flag` is 0 is dropped. A read while `out_flag` is 0 leaves `dout` and the level unchanged.
- R7: `almost_empty` is 1 exactly when the level is at or below the empty threshold. In fall-through mode the level includes the word held in the output register.
- R8: `almost_full` is 1 exactly when DEPTH minus the level is at or below the full threshold.
- R9: With `prog_serial` = 0, `ofs_load` high at an edge loads `ofs_ae_in` into the empty threshold and `ofs_af_in` into the full threshold.
- R10: With `prog_serial` = 1, each edge with `ser_en` high shifts `ser_bit` in, most significant bit first. The first CW bits fill the empty threshold and the next CW bits fill the full threshold. Later bits, and `ofs_load`, are ignored until the next master reset.
- R11: Words leave in the order they were written, the FIFO holds up to DEPTH words, and the level never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Synchronous master reset, active low |
| prst_n | input | 1 | Synchronous partial reset, active low |
| fsel | input | 2 | Default threshold select, sampled at master reset |
| fwft_sel | input | 1 | Timing mode select, sampled at master reset |
| prog_serial | input | 1 | 1 = serial threshold loading, 0 = parallel |
| ofs_load | input | 1 | Parallel threshold load strobe |
| ofs_ae_in | input | CW | Parallel value for the empty threshold |
| ofs_af_in | input | CW | Parallel value for the full threshold |
| ser_en | input | 1 | Serial shift enable |
| ser_bit | input | 1 | Serial threshold data bit |
| wr_en | input | 1 | Write request |
| din | input | W | Write data |
| rd_en | input | 1 | Read request |
| dout | output | W | Read data |
| in_flag | output | 1 | Not full (standard) / input ready (fall-through) |
| out_flag | output | 1 | Not empty (standard) / output valid (fall-through) |
| almost_empty | output | 1 | Level at or below the empty threshold |
| almost_full | output | 1 | Free space at or below the full threshold |

## Verification
The level and the threshold flags are updated at the same edge that accepts a write or read. They are therefore checked at the falling edge that follows that edge. In standard mode, read data is due on `dout` after the accepting edge. In fall-through mode, the word counted by a read is the one shown on `dout` before that edge. The bench's monitor keeps the previous half-cycle's `dout` and `out_flag`, so that each accepted read is compared against the correct value for the mode. A newly written word is checked to be absent after one edge and present after the second.

// File: rtl/pff_pkg.sv
package pff_pkg;

    typedef enum logic [1:0] {
        LD_EMPTY_OFS,
        LD_FULL_OFS,
        LD_LOCKED
    } ld_state_t;

    // Built-in threshold picked by the reset-time select
    function automatic int unsigned default_ofs(input logic [1:0] sel);
        if (sel[1])      return 64;
        else if (sel[0]) return 16;
        else             return 8;
    endfunction

endpackage

// File: rtl/pff_ofs_prog.sv
module pff_ofs_prog #(
    parameter int OFSW = 8,
    localparam int BCW = (OFSW > 1) ? $clog2(OFSW) : 1
) (
    input  logic            clk,
    input  logic            mrst_n,
    input  logic            prst_n,
    input  logic [1:0]      fsel,
    input  logic            prog_serial,
    input  logic            par_load,
    input  logic [OFSW-1:0] par_ae,
    input  logic [OFSW-1:0] par_af,
    input  logic            ser_en,
    input  logic            ser_bit,
    output logic [OFSW-1:0] ae_ofs,
    output logic [OFSW-1:0] af_ofs
);
    import pff_pkg::*;

    ld_state_t        state, state_nx;
    logic [BCW-1:0]   bcnt;
    logic             shift_ok, shift_ae, shift_af, last_bit;

    assign shift_ok = prog_serial && ser_en && prst_n;
    assign last_bit = (bcnt == BCW'(OFSW - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!mrst_n) state <= LD_EMPTY_OFS;
        else         state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            LD_EMPTY_OFS: if (shift_ok && last_bit) state_nx = LD_FULL_OFS;
            LD_FULL_OFS:  if (shift_ok && last_bit) state_nx = LD_LOCKED;
            LD_LOCKED:    state_nx = LD_LOCKED;
            default:      state_nx = LD_LOCKED;
        endcase
    end

    // outputs of the loader
    always_comb begin
        shift_ae = 1'b0;
        shift_af = 1'b0;
        unique case (state)
            LD_EMPTY_OFS: shift_ae = shift_ok;
            LD_FULL_OFS:  shift_af = shift_ok;
            default:      ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!mrst_n)                     bcnt <= '0;
        else if (shift_ae || shift_af)   bcnt <= last_bit ? '0 : bcnt + BCW'(1);
    end

    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            ae_ofs <= OFSW'(default_ofs(fsel));
            af_ofs <= OFSW'(default_ofs(fsel));
        end else if (prst_n) begin
            if (shift_ae)
                ae_ofs <= {ae_ofs[OFSW-2:0], ser_bit};
            else if (shift_af)
                af_ofs <= {af_ofs[OFSW-2:0], ser_bit};
            else if (!prog_serial && par_load) begin
                ae_ofs <= par_ae;
                af_ofs <= par_af;
            end
        end
    end

endmodule

// File: rtl/pff_store.sv
module pff_store #(
    parameter int W     = 36,
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] cnt
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wdata;
    end

    assign rdata = mem[rptr];

    always_ff @(posedge clk) begin
        if (clr) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push) wptr <= wptr + AW'(1);
            if (pop)  rptr <= rptr + AW'(1);
            unique case ({push, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo #(
    parameter int W     = 36,
    parameter int DEPTH = 128,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic [1:0]    fsel,
    input  logic          fwft_sel,
    input  logic          prog_serial,
    input  logic          ofs_load,
    input  logic [CW-1:0] ofs_ae_in,
    input  logic [CW-1:0] ofs_af_in,
    input  logic          ser_en,
    input  logic          ser_bit,
    input  logic          wr_en,
    input  logic [W-1:0]  din,
    input  logic          rd_en,
    output logic [W-1:0]  dout,
    output logic          in_flag,
    output logic          out_flag,
    output logic          almost_empty,
    output logic          almost_full
);
    logic          fwft_q, clr, push, pop, pop_std, fetch, ovalid;
    logic [W-1:0]  rdata;
    logic [CW-1:0] cnt, level, ae_ofs, af_ofs;

    assign clr = !mrst_n || !prst_n;

    always_ff @(posedge clk) begin
        if (!mrst_n) fwft_q <= fwft_sel;
    end

    pff_ofs_prog #(.OFSW(CW)) u_ofs (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .fsel(fsel),
        .prog_serial(prog_serial), .par_load(ofs_load),
        .par_ae(ofs_ae_in), .par_af(ofs_af_in),
        .ser_en(ser_en), .ser_bit(ser_bit),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs)
    );

    pff_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .clr(clr), .push(push), .pop(pop),
        .wdata(din), .rdata(rdata), .cnt(cnt)
    );

    assign level    = cnt + CW'(ovalid);
    assign in_flag  = level < CW'(DEPTH);
    assign out_flag = fwft_q ? ovalid : (cnt != '0);

    assign push    = wr_en && in_flag && !clr;
    assign pop_std = !fwft_q && rd_en && (cnt != '0);
    assign fetch   = fwft_q && (cnt != '0) && (!ovalid || rd_en);
    assign pop     = (pop_std || fetch) && !clr;

    always_ff @(posedge clk) begin
        if (clr) begin
            dout   <= '0;
            ovalid <= 1'b0;
        end else begin
            if (pop) dout <= rdata;
            if (fwft_q) begin
                if (fetch)      ovalid <= 1'b1;
                else if (rd_en) ovalid <= 1'b0;
            end
        end
    end

    assign almost_empty = level <= ae_ofs;
    assign almost_full  = (CW'(DEPTH) - level) <= af_ofs;

endmodule

// File: rtl/pff_chk.sv
module pff_chk #(
    parameter int DEPTH = 128,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          mrst_n,
    input logic          prst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          in_flag,
    input logic          out_flag,
    input logic          almost_empty,
    input logic [CW-1:0] level,
    input logic [CW-1:0] ae_ofs,
    input logic [CW-1:0] af_ofs
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !mrst_n |=> (!out_flag && in_flag && almost_empty));

    // R2
    ofs_keep_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        !prst_n |=> (ae_ofs == $past(ae_ofs) && af_ofs == $past(af_ofs)));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (!in_flag && wr_en && !rd_en) |=> level == $past(level));

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (!out_flag && rd_en && !wr_en) |=> level == $past(level));

    // R5
    same_edge_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (wr_en && rd_en && in_flag && out_flag) |=> level == $past(level));

    // R11
    level_bound_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        level <= CW'(DEPTH));

    // R3
    out_fall_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        ($fell(out_flag) && $past(mrst_n && prst_n)) |-> $past(rd_en));

endmodule

bind prog_flag_fifo pff_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .wr_en(wr_en), .rd_en(rd_en),
    .in_flag(in_flag), .out_flag(out_flag), .almost_empty(almost_empty),
    .level(level), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
);

// File: tb/sim_prog_flag_fifo.sv
`timescale 1ns/1ps
module sim_prog_flag_fifo;
    localparam int W  = 36;
    localparam int D  = 128;
    localparam int CW = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          mrst_n = 1'b0, prst_n = 1'b1;
    logic [1:0]    fsel = 2'b00;
    logic          fwft_sel = 1'b0, prog_serial = 1'b0, ofs_load = 1'b0;
    logic [CW-1:0] ofs_ae_in = '0, ofs_af_in = '0;
    logic          ser_en = 1'b0, ser_bit = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [W-1:0]  din = '0;
    logic [W-1:0]  dout;
    logic          in_flag, out_flag, almost_empty, almost_full;

    int            checks = 0, errors = 0;
    logic [W-1:0]  q[$];
    bit            fwft_mode = 1'b0;
    logic          prev_out = 1'b0;
    logic [W-1:0]  prev_dout = '0;

    prog_flag_fifo #(.W(W), .DEPTH(D)) u0 (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .fsel(fsel),
        .fwft_sel(fwft_sel), .prog_serial(prog_serial), .ofs_load(ofs_load),
        .ofs_ae_in(ofs_ae_in), .ofs_af_in(ofs_af_in), .ser_en(ser_en),
        .ser_bit(ser_bit), .wr_en(wr_en), .din(din), .rd_en(rd_en),
        .dout(dout), .in_flag(in_flag), .out_flag(out_flag),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [W-1:0] v);
        if (in_flag) q.push_back(v);
        wr_en = 1'b1; din = v;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd();
        rd_en = 1'b1;
        step();
        rd_en = 1'b0;
    endtask

    task automatic wrrd(input logic [W-1:0] v);
        if (in_flag) q.push_back(v);
        wr_en = 1'b1; rd_en = 1'b1; din = v;
        step();
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic mreset(input logic [1:0] fs, input logic fw, input logic ser);
        mrst_n = 1'b0; fsel = fs; fwft_sel = fw; prog_serial = ser;
        step();
        mrst_n = 1'b1;
        q.delete();
        fwft_mode = fw;
    endtask

    task automatic preset();
        prst_n = 1'b0;
        step();
        prst_n = 1'b1;
        q.delete();
    endtask

    task automatic sbit(input logic b);
        ser_en = 1'b1; ser_bit = b;
        step();
        ser_en = 1'b0;
    endtask

    // scoreboard monitor: compares every accepted read against the queue
    always @(negedge clk) begin
        if (rd_en && prev_out && mrst_n && prst_n) begin
            if (q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11 unexpected read: actual %0h expected none", dout);
            end else begin
                logic [W-1:0] e;
                e = q.pop_front();
                if (fwft_mode) chk("R4 fall-through data", 64'(prev_dout), 64'(e));
                else           chk("R3 standard data", 64'(dout), 64'(e));
            end
        end
        prev_out  = out_flag;
        prev_dout = dout;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R11 watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] d0;
        int n;
        // ---- R1 reset state, default 8, standard mode
        mreset(2'b00, 1'b0, 1'b0);
        chk("R1 out_flag", out_flag, 0);
        chk("R1 in_flag", in_flag, 1);
        chk("R1 almost_empty", almost_empty, 1);
        chk("R8 almost_full at empty", almost_full, 0);
        for (int i = 0; i < 8; i++) wr(36'hA0000 + i);
        chk("R7 ae at level 8", almost_empty, 1);
        wr(36'hA0008);
        chk("R7 ae at level 9", almost_empty, 0);
        chk("R3 out_flag not empty", out_flag, 1);
        rd();
        chk("R3 dout after read", dout, 36'hA0000);
        wrrd(36'hB0000);
        chk("R5 ae level unchanged at 8", almost_empty, 1);
        while (out_flag) rd();
        chk("R11 queue drained", q.size(), 0);
        d0 = dout;
        rd();
        chk("R6 read when empty keeps dout", dout, d0);
        chk("R6 still empty", out_flag, 0);

        // ---- R1 default 64, full boundary and overflow
        mreset(2'b10, 1'b0, 1'b0);
        for (int i = 0; i < 63; i++) wr(36'hC0000 + i);
        chk("R8 af at level 63", almost_full, 0);
        wr(36'hC003F);
        chk("R8 af at level 64", almost_full, 1);
        chk("R1 ae default 64 at level 64", almost_empty, 1);
        wr(36'hC0040);
        chk("R1 ae default 64 at level 65", almost_empty, 0);
        for (int i = 65; i < D; i++) wr(36'hC0000 + i);
        chk("R3 in_flag low when full", in_flag, 0);
        wr(36'hBAD);
        n = 0;
        while (out_flag) begin rd(); n++; end
        chk("R6 write when full dropped", n, D);

        // ---- R9 parallel load
        mreset(2'b00, 1'b0, 1'b0);
        ofs_ae_in = 8'd3; ofs_af_in = 8'd5; ofs_load = 1'b1;
        step();
        ofs_load = 1'b0;
        for (int i = 0; i < 3; i++) wr(36'hD0000 + i);
        chk("R9 ae loaded 3 at level 3", almost_empty, 1);
        wr(36'hD0003);
        chk("R9 ae loaded 3 at level 4", almost_empty, 0);

        // ---- R2 partial reset keeps thresholds
        preset();
        chk("R2 out_flag after partial", out_flag, 0);
        chk("R2 ae after partial", almost_empty, 1);
        for (int i = 0; i < 3; i++) wr(36'hE0000 + i);
        chk("R2 threshold 3 kept at level 3", almost_empty, 1);
        wr(36'hE0003);
        chk("R2 threshold 3 kept at level 4", almost_empty, 0);
        while (out_flag) rd();

        // ---- R4 fall-through, default 16
        mreset(2'b01, 1'b1, 1'b0);
        wr(36'hF0001);
        chk("R4 not shown after one edge", out_flag, 0);
        step();
        chk("R4 shown after two edges", out_flag, 1);
        chk("R4 word without request", dout, 36'hF0001);
        rd();
        chk("R4 consumed", out_flag, 0);
        for (int i = 0; i < 16; i++) wr(36'hF1000 + i);
        chk("R7 fwft ae at level 16", almost_empty, 1);
        wr(36'hF1010);
        chk("R7 fwft ae at level 17", almost_empty, 0);
        step();
        wrrd(36'hF2000);
        chk("R5 fwft same edge level 17", almost_empty, 0);
        while (out_flag) rd();
        chk("R11 fwft drained", q.size(), 0);

        // ---- R2 mode retained by partial reset
        preset();
        wr(36'hF3000);
        step();
        chk("R2 fwft mode kept", out_flag, 1);
        rd();

        // ---- R10 serial load: ae=5, af=10
        mreset(2'b00, 1'b0, 1'b1);
        for (int b = CW - 1; b >= 0; b--) sbit(8'd5 >> b);
        for (int b = CW - 1; b >= 0; b--) sbit(8'd10 >> b);
        for (int b = 0; b < CW; b++) sbit(1'b1);
        ofs_ae_in = 8'd100; ofs_af_in = 8'd100; ofs_load = 1'b1;
        step();
        ofs_load = 1'b0;
        for (int i = 0; i < 5; i++) wr(36'h50000 + i);
        chk("R10 serial ae 5 at level 5", almost_empty, 1);
        wr(36'h50005);
        chk("R10 serial ae 5 at level 6", almost_empty, 0);
        for (int i = 6; i < 117; i++) wr(36'h50000 + i);
        chk("R10 serial af 10 at level 117", almost_full, 0);
        wr(36'h50075);
        chk("R10 serial af 10 at level 118", almost_full, 1);
        while (out_flag) rd();
        chk("R11 serial run drained", q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule